// File: doc/BRIEF.md
# Operand and Branch Address Generator

This unit computes the addresses and immediate operands that a small RISC core needs once an instruction is decoded. Each cycle the decoder may present a request: a base register value, the current program counter, a 22-bit instruction field, a mode code and an immediate-extension control. One cycle later the unit presents the registered result with a valid strobe.

The unit supports a fixed set of simple modes. Data accesses use a base register plus a sign-extended 16-bit displacement. This includes single-bit accesses, which address one byte. Branch targets are the PC plus a sign-extended 9-bit or 22-bit displacement, or the PC is loaded from a register. Five-bit and sixteen-bit immediates are extended to full width.

Instruction addresses are confined to a 26-bit space and are halfword aligned. There are three result registers: one for data addresses, one for branch targets and one for immediates. Each one changes only when a request of its own class arrives and holds its value otherwise.

Top module: `addr_gen_unit`

## Requirements
- R1: Mode codes are 0 based, 1 bit-access, 2 short relative, 3 long relative, 4 register indirect, 5 small immediate, 6 large immediate. In mode 0, `data_addr` becomes `base_val` plus `field[15:0]` sign-extended to 32 bits, modulo 2^32.
- R2: In mode 1, `data_addr` is formed by the same sum as mode 0 (byte address of the bit).
- R3: In mode 2, `next_pc` becomes `pc_val` plus `field[8:0]` sign-extended, masked as in R6.
- R4: In mode 3, `next_pc` becomes `pc_val` plus `field[21:0]` sign-extended, masked as in R6.
- R5: In mode 4, `next_pc` becomes `base_val`, masked as in R6.
- R6: Every value written to `next_pc` has bits 31..26 zero and bit 0 zero (mask 0x03FF_FFFE).
- R7: In mode 5, `imm_out` is `field[4:0]` zero-extended when `imm_zext` is 1 and sign-extended when it is 0.
- R8: In mode 6, `imm_out` is `field[15:0]` sign-extended.
- R9: `out_valid` is high exactly one cycle after a cycle with `req_valid` high, and results appear in that same cycle.
- R10: A result register changes only on a valid request of its own class (data: modes 0–1; branch: 2–4; immediate: 5–6). Mode 7, and any cycle without `req_valid`, leaves all three outputs unchanged.
- R11: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mode_sel | input | 3 | Mode code (see R1) |
| imm_zext | input | 1 | 1: zero-extend small immediate, 0: sign-extend |
| base_val | input | 32 | General register contents |
| pc_val | input | 32 | Current program counter |
| field | input | 22 | Displacement/immediate field of the instruction |
| out_valid | output | 1 | Result strobe, one cycle after request |
| data_addr | output | 32 | Data operand address |
| next_pc | output | 32 | Branch target address |
| imm_out | output | 32 | Extended immediate |

## Verification
A wrong extension rule shows up in the first result cycle after the request, as bad upper bits. It appears only when the displacement's top bit is set, so negative and boundary displacements are driven in every mode. A wrong class decode overwrites a register that should hold, which becomes visible as soon as a request of another class or mode 7 follows. The tests therefore interleave classes. A mask error shows as a nonzero bit 0 or a nonzero bit above 25 on the first branch result whose sum reaches those bits.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_BASED  = 3'd0,
    AM_BIT    = 3'd1,
    AM_REL_S  = 3'd2,
    AM_REL_L  = 3'd3,
    AM_REGIND = 3'd4,
    AM_IMM_S  = 3'd5,
    AM_IMM_L  = 3'd6,
    AM_RSVD   = 3'd7
  } agu_mode_e;

  function automatic logic is_data_mode(agu_mode_e m);
    return (m == AM_BASED) || (m == AM_BIT);
  endfunction

  function automatic logic is_branch_mode(agu_mode_e m);
    return (m == AM_REL_S) || (m == AM_REL_L) || (m == AM_REGIND);
  endfunction

  function automatic logic is_imm_mode(agu_mode_e m);
    return (m == AM_IMM_S) || (m == AM_IMM_L);
  endfunction
endpackage

// File: rtl/agu_data_path.sv
module agu_data_path #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] addr
);
  function automatic logic [AW-1:0] sext_disp(input logic [DW-1:0] v);
    return {{(AW-DW){v[DW-1]}}, v};
  endfunction

  assign addr = base + sext_disp(disp);
endmodule

// File: rtl/agu_branch_path.sv
module agu_branch_path #(
  parameter int AW  = 32,
  parameter int FW  = 22,
  parameter int SW  = 9,
  parameter int PCB = 26
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] base,
  input  logic [FW-1:0] fld,
  input  logic          sel_long,
  input  logic          sel_reg,
  output logic [AW-1:0] target
);
  localparam logic [AW-1:0] ONE     = 1;
  localparam logic [AW-1:0] PC_MASK = (ONE << PCB) - ONE - ONE;

  function automatic logic [AW-1:0] sext_short(input logic [SW-1:0] v);
    return {{(AW-SW){v[SW-1]}}, v};
  endfunction

  function automatic logic [AW-1:0] sext_long(input logic [FW-1:0] v);
    return {{(AW-FW){v[FW-1]}}, v};
  endfunction

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] raw_target;

  assign disp_ext   = sel_long ? sext_long(fld) : sext_short(fld[SW-1:0]);
  assign raw_target = sel_reg ? base : (pc + disp_ext);
  assign target     = raw_target & PC_MASK;
endmodule

// File: rtl/agu_imm_path.sv
module agu_imm_path #(
  parameter int AW = 32,
  parameter int SW = 5,
  parameter int LW = 16
) (
  input  logic [LW-1:0] fld,
  input  logic          zext,
  input  logic          sel_long,
  output logic [AW-1:0] imm
);
  function automatic logic [AW-1:0] ext_small(input logic [SW-1:0] v, input logic z);
    return {{(AW-SW){v[SW-1] & ~z}}, v};
  endfunction

  function automatic logic [AW-1:0] ext_large(input logic [LW-1:0] v);
    return {{(AW-LW){v[LW-1]}}, v};
  endfunction

  assign imm = sel_long ? ext_large(fld) : ext_small(fld[SW-1:0], zext);
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int AW  = 32,
  parameter int FW  = 22,
  parameter int DW  = 16,
  parameter int SW  = 9,
  parameter int IW  = 5,
  parameter int PCB = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    mode_sel,
  input  logic          imm_zext,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] pc_val,
  input  logic [FW-1:0] field,
  output logic          out_valid,
  output logic [AW-1:0] data_addr,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] imm_out
);
  import agu_pkg::*;

  agu_mode_e     mode_e;
  logic          data_hit;
  logic          branch_hit;
  logic          imm_hit;
  logic [AW-1:0] data_nxt;
  logic [AW-1:0] branch_nxt;
  logic [AW-1:0] imm_nxt;

  assign mode_e     = agu_mode_e'(mode_sel);
  assign data_hit   = req_valid && is_data_mode(mode_e);
  assign branch_hit = req_valid && is_branch_mode(mode_e);
  assign imm_hit    = req_valid && is_imm_mode(mode_e);

  agu_data_path #(.AW(AW), .DW(DW)) u_data (
    .base (base_val),
    .disp (field[DW-1:0]),
    .addr (data_nxt)
  );

  agu_branch_path #(.AW(AW), .FW(FW), .SW(SW), .PCB(PCB)) u_branch (
    .pc       (pc_val),
    .base     (base_val),
    .fld      (field),
    .sel_long (mode_e == AM_REL_L),
    .sel_reg  (mode_e == AM_REGIND),
    .target   (branch_nxt)
  );

  agu_imm_path #(.AW(AW), .SW(IW), .LW(DW)) u_imm (
    .fld      (field[DW-1:0]),
    .zext     (imm_zext),
    .sel_long (mode_e == AM_IMM_L),
    .imm      (imm_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      data_addr <= '0;
      next_pc   <= '0;
      imm_out   <= '0;
    end else begin
      out_valid <= req_valid;
      if (data_hit)   data_addr <= data_nxt;
      if (branch_hit) next_pc   <= branch_nxt;
      if (imm_hit)    imm_out   <= imm_nxt;
    end
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int AW  = 32,
  parameter int FW  = 22,
  parameter int DW  = 16,
  parameter int PCB = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    mode_sel,
  input logic [AW-1:0] base_val,
  input logic [FW-1:0] field,
  input logic          out_valid,
  input logic [AW-1:0] data_addr,
  input logic [AW-1:0] next_pc,
  input logic [AW-1:0] imm_out,
  input logic          data_hit,
  input logic          branch_hit,
  input logic          imm_hit
);
  // R1
  based_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_sel == 3'd0) |=>
      data_addr == $past(base_val) + {{(AW-DW){$past(field[DW-1])}}, $past(field[DW-1:0])});

  // R6
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !next_pc[0] && (next_pc >> PCB) == '0);

  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_hit |=> $stable(data_addr));

  // R10
  branch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !branch_hit |=> $stable(next_pc));

  // R10
  imm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !imm_hit |=> $stable(imm_out));

  // R10
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_hit, branch_hit, imm_hit}));
endmodule

bind addr_gen_unit agu_chk #(.AW(AW), .FW(FW), .DW(DW), .PCB(PCB)) u_agu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .mode_sel   (mode_sel),
  .base_val   (base_val),
  .field      (field),
  .out_valid  (out_valid),
  .data_addr  (data_addr),
  .next_pc    (next_pc),
  .imm_out    (imm_out),
  .data_hit   (data_hit),
  .branch_hit (branch_hit),
  .imm_hit    (imm_hit)
);

// File: tb/test_addr_gen_unit.sv
module test_addr_gen_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic        imm_zext = 1'b0;
  logic [31:0] base_val = '0;
  logic [31:0] pc_val = '0;
  logic [21:0] field = '0;
  logic        out_valid;
  logic [31:0] data_addr;
  logic [31:0] next_pc;
  logic [31:0] imm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  addr_gen_unit i_addr_gen_unit (
    .clk, .rst_n, .req_valid, .mode_sel, .imm_zext, .base_val, .pc_val,
    .field, .out_valid, .data_addr, .next_pc, .imm_out
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference arithmetic, written in signed integer form.
  function automatic logic [31:0] ref_s16(logic [15:0] v);
    return 32'(int'(signed'(v)));
  endfunction
  function automatic logic [31:0] ref_s9(logic [8:0] v);
    return 32'($signed({v, 23'b0}) >>> 23);
  endfunction
  function automatic logic [31:0] ref_s22(logic [21:0] v);
    return 32'($signed({v, 10'b0}) >>> 10);
  endfunction
  function automatic logic [31:0] ref_pcfix(logic [31:0] v);
    return v & 32'h03FF_FFFE;
  endfunction

  // Drive one request at a falling edge, sample one full cycle later.
  task automatic issue(logic [2:0] m, logic [31:0] b, logic [31:0] p, logic [21:0] f, logic z);
    @(negedge clk);
    req_valid = 1'b1; mode_sel = m; base_val = b; pc_val = p; field = f; imm_zext = z;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R11 valid", {31'b0, out_valid}, 32'd0);
    check("R11 data", data_addr, 32'd0);
    check("R11 pc", next_pc, 32'd0);
    check("R11 imm", imm_out, 32'd0);
  endtask

  task automatic t_based;
    issue(3'd0, 32'h0000_1000, 32'h0, 22'h0_0234, 1'b0);
    check("R9 strobe", {31'b0, out_valid}, 32'd1);
    check("R1 pos disp", data_addr, 32'h0000_1234);
    issue(3'd0, 32'h0000_1000, 32'h0, 22'h3F_8000, 1'b0);
    check("R1 neg disp", data_addr, 32'h0000_1000 + ref_s16(16'h8000));
    issue(3'd0, 32'hFFFF_FFF0, 32'h0, 22'h0_0020, 1'b0);
    check("R1 wrap", data_addr, 32'h0000_0010);
  endtask

  task automatic t_bit;
    issue(3'd1, 32'h2000_0000, 32'h0, 22'h0_FFFF, 1'b0);
    check("R2 bit addr", data_addr, 32'h1FFF_FFFF);
  endtask

  task automatic t_rel9;
    issue(3'd2, 32'h0, 32'h0000_0100, 22'h00_0FE, 1'b0);
    check("R3 fwd", next_pc, ref_pcfix(32'h100 + ref_s9(9'h0FE)));
    issue(3'd2, 32'h0, 32'h0000_0100, 22'h3F_F100, 1'b0);
    check("R3 min disp", next_pc, ref_pcfix(32'h100 + ref_s9(9'h100)));
    issue(3'd2, 32'h0, 32'h0000_0101, 22'h00_0002, 1'b0);
    check("R6 odd sum", next_pc, 32'h0000_0102);
  endtask

  task automatic t_rel22;
    issue(3'd3, 32'h0, 32'h0000_0040, 22'h20_0000, 1'b0);
    check("R4 neg", next_pc, ref_pcfix(32'h40 + ref_s22(22'h20_0000)));
    issue(3'd3, 32'h0, 32'h03FF_FF00, 22'h00_0200, 1'b0);
    check("R6 high wrap", next_pc, 32'h0000_0100);
  endtask

  task automatic t_regind;
    issue(3'd4, 32'hFFFF_FFFF, 32'h0000_1234, 22'h15_5555, 1'b0);
    check("R5 reg load", next_pc, 32'h03FF_FFFE);
  endtask

  task automatic t_imm;
    issue(3'd5, 32'h0, 32'h0, 22'h00_0010, 1'b0);
    check("R7 sext", imm_out, 32'hFFFF_FFF0);
    issue(3'd5, 32'h0, 32'h0, 22'h3F_FFF0, 1'b1);
    check("R7 zext", imm_out, 32'h0000_0010);
    issue(3'd5, 32'h0, 32'h0, 22'h00_000F, 1'b0);
    check("R7 pos", imm_out, 32'h0000_000F);
    issue(3'd6, 32'h0, 32'h0, 22'h00_8001, 1'b1);
    check("R8 neg", imm_out, ref_s16(16'h8001));
    issue(3'd6, 32'h0, 32'h0, 22'h3F_7FFF, 1'b0);
    check("R8 pos", imm_out, 32'h0000_7FFF);
  endtask

  task automatic t_isolation;
    logic [31:0] d0, p0, i0;
    issue(3'd0, 32'h0000_5000, 32'h0, 22'h0_0004, 1'b0);
    issue(3'd2, 32'h0, 32'h0000_0200, 22'h00_0010, 1'b0);
    issue(3'd6, 32'h0, 32'h0, 22'h00_1234, 1'b0);
    d0 = data_addr; p0 = next_pc; i0 = imm_out;
    check("R10 data kept", d0, 32'h0000_5004);
    check("R10 pc kept", p0, 32'h0000_0210);
    issue(3'd7, 32'hDEAD_BEEF, 32'h0000_0FFF, 22'h3F_FFFF, 1'b1);
    check("R9 strobe rsvd", {31'b0, out_valid}, 32'd1);
    check("R10 rsvd data", data_addr, d0);
    check("R10 rsvd pc", next_pc, p0);
    check("R10 rsvd imm", imm_out, i0);
    @(negedge clk);
    base_val = 32'h1111_1111; mode_sel = 3'd0; field = 22'h0_1111;
    @(negedge clk);
    check("R9 idle", {31'b0, out_valid}, 32'd0);
    check("R10 idle data", data_addr, d0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_based;
    t_bit;
    t_rel9;
    t_rel22;
    t_regind;
    t_imm;
    t_isolation;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule